// File: doc/BRIEF.md
# PCIe Configuration Window Base Decoder

This block holds the 64-bit host-bridge register that places the memory-mapped PCIe configuration window in physical address space. The register carries an enable bit, a two-bit length code and the window base. Each time the register changes, the block decodes those fields into an active window, which is a base and a size of 256, 128 or 64 MiB. It then checks every physical address presented on its lookup port against that window. When the address hits, the block splits the offset into the bus, device, function and register numbers of the configuration access.

Firmware programs the register through a byte-enabled write port. A separate restore port loads the whole register at once and recomputes the window, as a write does. Where a smaller window is selected, more of the low base bits take part in the base. If the length code is reserved, the previous window stays active and a one-cycle guest-error flag is raised. The register itself still reads back exactly what was written.

Top module: `cfgwin_decoder`

## Requirements
- R1: After reset the register reads 64'h0000_0000_B000_0001, and the active window is enabled with base 36'h0_B000_0000 and length code 00 (256 MiB).
- R2: When the active window's enable (register bit 0 at its last decode) is 0, no lookup reports a hit.
- R3: The length code is register bits 2:1: 00 selects 256 MiB with base bits 35:28, 01 selects 128 MiB with base bits 35:27, and 10 selects 64 MiB with base bits 35:26. The base bits below the window size are zero.
- R4: A decode of length code 11 leaves enable, base and length of the active window unchanged, and raises guest_err for exactly the following cycle.
- R5: A write with at least one byte-enable set updates only the enabled bytes, each byte i covering bits 8i+7:8i. The window is decoded from the merged value in the same edge. A write with all byte-enables clear changes nothing.
- R6: Lookup presented with lk_valid=1 reports lk_hit=1 one cycle later exactly when base <= addr < base + size for the window active at the presenting edge. With lk_valid=0, lk_hit is 0.
- R7: On a hit, lk_bus = offset[27:20], lk_dev = offset[19:15], lk_fn = offset[14:12] and lk_reg = offset[11:0], where offset = addr - base. On a miss all four are zero.
- R8: rs_en loads the full 64-bit rs_data and decodes it like a write. It takes priority over a write in the same cycle.
- R9: rd_data always shows the stored register, including values written with the reserved length code and bits outside the decoded fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_be | input | 8 | Byte enables of the write |
| wr_data | input | 64 | Write data |
| rs_en | input | 1 | State-restore strobe |
| rs_data | input | 64 | Full register value to restore |
| rd_data | output | 64 | Current register contents |
| lk_valid | input | 1 | Lookup request valid |
| lk_addr | input | 36 | Physical address to check |
| lk_hit | output | 1 | Address falls in the active window |
| lk_bus | output | 8 | Decoded bus number |
| lk_dev | output | 5 | Decoded device number |
| lk_fn | output | 3 | Decoded function number |
| lk_reg | output | 12 | Decoded register offset |
| win_en | output | 1 | Active window enabled |
| win_base | output | 36 | Active window base |
| win_len | output | 2 | Length code of the active window |
| guest_err | output | 1 | Reserved length code was decoded in the previous cycle |

## Verification
A write or restore registers at the edge where it is presented. rd_data and the window outputs change at that edge, and guest_err is high for the cycle that follows it. A lookup result appears one edge after the address is presented, and it is judged against the window that was active before that edge. This means a lookup issued in the same cycle as a write still sees the old window. The bench model advances at every rising edge in the same order: first it resolves the lookup against its previous window, then it applies the write. All outputs are compared one nanosecond after each edge, with inputs changed at that same point.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;

  typedef enum logic [1:0] {
    LEN_256M = 2'b00,
    LEN_128M = 2'b01,
    LEN_64M  = 2'b10,
    LEN_RSV  = 2'b11
  } len_code_e;

  // log2 of the window size for a non-reserved length code
  function automatic int unsigned len_log2(input len_code_e code, input int unsigned top_log2);
    return top_log2 - int'(code);
  endfunction

  function automatic logic is_reserved(input len_code_e code);
    return code == LEN_RSV;
  endfunction

endpackage

// File: rtl/cfgwin_reg.sv
module cfgwin_reg #(
  parameter int unsigned REG_W     = 64,
  parameter int unsigned ADDR_W    = 36,
  parameter logic [63:0] RESET_VAL = 64'h0000_0000_B000_0001,
  localparam int unsigned BE_W     = REG_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BE_W-1:0]   wr_be,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              rs_en,
  input  logic [REG_W-1:0]  rs_data,
  output logic [REG_W-1:0]  reg_q,
  output logic [ADDR_W-1:0] nxt_low,
  output logic              upd
);

  logic [REG_W-1:0] merged;
  logic [REG_W-1:0] nxt;

  generate
    for (genvar b = 0; b < BE_W; b++) begin : g_lane
      assign merged[8*b +: 8] = wr_be[b] ? wr_data[8*b +: 8] : reg_q[8*b +: 8];
    end
  endgenerate

  assign upd     = rs_en | (wr_en & (|wr_be));
  assign nxt     = rs_en ? rs_data : merged;
  assign nxt_low = nxt[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n)   reg_q <= RESET_VAL[REG_W-1:0];
    else if (upd) reg_q <= nxt;
  end

  // R5
  lane0_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_be[0] && !rs_en) |=> $stable(reg_q[7:0]));

  // R8
  restore_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rs_en |=> (reg_q == $past(rs_data)));

endmodule

// File: rtl/cfgwin_window.sv
module cfgwin_window
  import cfgwin_pkg::*;
#(
  parameter int unsigned ADDR_W    = 36,
  parameter int unsigned TOP_LOG2  = 28,
  parameter logic [63:0] RESET_VAL = 64'h0000_0000_B000_0001,
  localparam int unsigned LOG2_W   = $clog2(ADDR_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd,
  input  logic [ADDR_W-1:0] nxt_low,
  output logic              win_en,
  output logic [ADDR_W-1:0] win_base,
  output len_code_e         win_code,
  output logic [LOG2_W-1:0] win_log2,
  output logic              guest_err
);

  len_code_e         new_code;
  logic [LOG2_W-1:0] new_log2;
  logic [ADDR_W-1:0] new_base;
  logic              rsv_upd;
  logic              good_upd;

  len_code_e         rst_code;
  logic [LOG2_W-1:0] rst_log2;

  assign new_code = len_code_e'(nxt_low[2:1]);
  assign new_log2 = LOG2_W'(len_log2(new_code, TOP_LOG2));
  assign new_base = nxt_low & ({ADDR_W{1'b1}} << new_log2);
  assign rsv_upd  = upd & is_reserved(new_code);
  assign good_upd = upd & ~is_reserved(new_code);

  assign rst_code = len_code_e'(RESET_VAL[2:1]);
  assign rst_log2 = LOG2_W'(len_log2(rst_code, TOP_LOG2));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_en    <= RESET_VAL[0];
      win_code  <= rst_code;
      win_log2  <= rst_log2;
      win_base  <= RESET_VAL[ADDR_W-1:0] & ({ADDR_W{1'b1}} << rst_log2);
      guest_err <= 1'b0;
    end else begin
      guest_err <= rsv_upd;
      if (good_upd) begin
        win_en   <= nxt_low[0];
        win_code <= new_code;
        win_log2 <= new_log2;
        win_base <= new_base;
      end
    end
  end

  // R4
  rsv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsv_upd |=> ($stable(win_base) && $stable(win_en) && $stable(win_code)));

  // R4
  rsv_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsv_upd |=> guest_err);

  // R4
  flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    guest_err |-> $past(rsv_upd));

  // R3
  base_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_base & ~({ADDR_W{1'b1}} << win_log2)) == '0);

  // R3
  code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_code != LEN_RSV);

endmodule

// File: rtl/cfgwin_lookup.sv
module cfgwin_lookup #(
  parameter int unsigned ADDR_W  = 36,
  localparam int unsigned LOG2_W = $clog2(ADDR_W + 1),
  localparam int unsigned OFF_W  = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic              win_en,
  input  logic [ADDR_W-1:0] win_base,
  input  logic [LOG2_W-1:0] win_log2,
  output logic              lk_hit,
  output logic [7:0]        lk_bus,
  output logic [4:0]        lk_dev,
  output logic [2:0]        lk_fn,
  output logic [11:0]       lk_reg
);

  logic [ADDR_W-1:0] keep_mask;
  logic              in_win;
  logic [OFF_W-1:0]  off;

  assign keep_mask = {ADDR_W{1'b1}} << win_log2;
  assign in_win    = lk_valid & win_en & ((lk_addr & keep_mask) == win_base);
  assign off       = lk_addr[OFF_W-1:0] - win_base[OFF_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lk_hit <= 1'b0;
      lk_bus <= '0;
      lk_dev <= '0;
      lk_fn  <= '0;
      lk_reg <= '0;
    end else begin
      lk_hit <= in_win;
      lk_bus <= in_win ? off[27:20] : '0;
      lk_dev <= in_win ? off[19:15] : '0;
      lk_fn  <= in_win ? off[14:12] : '0;
      lk_reg <= in_win ? off[11:0]  : '0;
    end
  end

  // R6
  hit_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> $past(lk_valid));

  // R2
  hit_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> $past(win_en));

  // R7
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_bus == '0 && lk_dev == '0 && lk_fn == '0 && lk_reg == '0));

endmodule

// File: rtl/cfgwin_decoder.sv
module cfgwin_decoder
  import cfgwin_pkg::*;
#(
  parameter int unsigned REG_W     = 64,
  parameter int unsigned ADDR_W    = 36,
  parameter int unsigned TOP_LOG2  = 28,
  parameter logic [63:0] RESET_VAL = 64'h0000_0000_B000_0001,
  localparam int unsigned BE_W     = REG_W / 8,
  localparam int unsigned LOG2_W   = $clog2(ADDR_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BE_W-1:0]   wr_be,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              rs_en,
  input  logic [REG_W-1:0]  rs_data,
  output logic [REG_W-1:0]  rd_data,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit,
  output logic [7:0]        lk_bus,
  output logic [4:0]        lk_dev,
  output logic [2:0]        lk_fn,
  output logic [11:0]       lk_reg,
  output logic              win_en,
  output logic [ADDR_W-1:0] win_base,
  output logic [1:0]        win_len,
  output logic              guest_err
);

  logic [ADDR_W-1:0] nxt_low;
  logic              upd;
  len_code_e         win_code;
  logic [LOG2_W-1:0] win_log2;

  cfgwin_reg #(
    .REG_W(REG_W), .ADDR_W(ADDR_W), .RESET_VAL(RESET_VAL)
  ) u_reg (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
    .rs_en(rs_en), .rs_data(rs_data),
    .reg_q(rd_data), .nxt_low(nxt_low), .upd(upd)
  );

  cfgwin_window #(
    .ADDR_W(ADDR_W), .TOP_LOG2(TOP_LOG2), .RESET_VAL(RESET_VAL)
  ) u_win (
    .clk(clk), .rst_n(rst_n), .upd(upd), .nxt_low(nxt_low),
    .win_en(win_en), .win_base(win_base), .win_code(win_code),
    .win_log2(win_log2), .guest_err(guest_err)
  );

  cfgwin_lookup #(
    .ADDR_W(ADDR_W)
  ) u_lk (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_addr(lk_addr),
    .win_en(win_en), .win_base(win_base), .win_log2(win_log2),
    .lk_hit(lk_hit), .lk_bus(lk_bus), .lk_dev(lk_dev),
    .lk_fn(lk_fn), .lk_reg(lk_reg)
  );

  assign win_len = win_code;

endmodule

// File: tb/cfgwin_decoder_test.sv
`timescale 1ns/1ps
module cfgwin_decoder_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_be = '0;
  logic [63:0] wr_data = '0;
  logic        rs_en = 1'b0;
  logic [63:0] rs_data = '0;
  logic [63:0] rd_data;
  logic        lk_valid = 1'b0;
  logic [35:0] lk_addr = '0;
  logic        lk_hit;
  logic [7:0]  lk_bus;
  logic [4:0]  lk_dev;
  logic [2:0]  lk_fn;
  logic [11:0] lk_reg;
  logic        win_en;
  logic [35:0] win_base;
  logic [1:0]  win_len;
  logic        guest_err;

  always #2 clk = ~clk;

  cfgwin_decoder uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
    .rs_en(rs_en), .rs_data(rs_data), .rd_data(rd_data),
    .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_bus(lk_bus),
    .lk_dev(lk_dev), .lk_fn(lk_fn), .lk_reg(lk_reg),
    .win_en(win_en), .win_base(win_base), .win_len(win_len), .guest_err(guest_err)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference state
  logic [63:0] m_reg;
  logic        m_en;
  logic [35:0] m_base;
  logic [1:0]  m_len;
  logic        e_err;
  logic        e_hit;
  logic [27:0] e_off;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_reg  = 64'h0000_0000_B000_0001;
    m_en   = 1'b1;
    m_base = 36'h0_B000_0000;
    m_len  = 2'b00;
    e_err  = 1'b0;
    e_hit  = 1'b0;
    e_off  = '0;
  endtask

  // one clock: model advances at the edge, outputs compared 1 ns later
  task automatic tick();
    logic [63:0] nv;
    longint unsigned sz;
    @(posedge clk);
    // lookup against the window active before this edge
    sz = 64'd1 << (28 - m_len);
    e_hit = lk_valid && m_en && ({28'd0, lk_addr} >= {28'd0, m_base}) &&
            ({28'd0, lk_addr} < ({28'd0, m_base} + sz));
    e_off = e_hit ? 28'(lk_addr - m_base) : 28'd0;
    // register update
    e_err = 1'b0;
    if (rs_en || (wr_en && wr_be != 0)) begin
      if (rs_en) nv = rs_data;
      else begin
        nv = m_reg;
        for (int b = 0; b < 8; b++) if (wr_be[b]) nv[8*b +: 8] = wr_data[8*b +: 8];
      end
      m_reg = nv;
      if (nv[2:1] == 2'b11) e_err = 1'b1;
      else begin
        m_en   = nv[0];
        m_len  = nv[2:1];
        m_base = nv[35:0] & ~((36'd1 << (28 - nv[2:1])) - 36'd1);
      end
    end
    #1;
    check("R9 rd_data", rd_data, m_reg);
    check("R3 win_base", 64'(win_base), 64'(m_base));
    check("R3 win_len", 64'(win_len), 64'(m_len));
    check("R2 win_en", 64'(win_en), 64'(m_en));
    check("R4 guest_err", 64'(guest_err), 64'(e_err));
    check("R6 lk_hit", 64'(lk_hit), 64'(e_hit));
    check("R7 fields", {28'd0, lk_bus, lk_dev, lk_fn, lk_reg},
          {36'd0, e_off});
  endtask

  task automatic idle();
    wr_en = 0; wr_be = 0; rs_en = 0; lk_valid = 0;
  endtask

  task automatic do_write(input logic [7:0] be, input logic [63:0] d);
    idle(); wr_en = 1; wr_be = be; wr_data = d; tick(); idle();
  endtask

  task automatic do_look(input logic [35:0] a);
    idle(); lk_valid = 1; lk_addr = a; tick(); idle();
  endtask

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: reset state
    check("R1 rd_data", rd_data, 64'h0000_0000_B000_0001);
    check("R1 win_base", 64'(win_base), 64'h0_B000_0000);
    check("R1 win_en", 64'(win_en), 64'd1);
    check("R1 win_len", 64'(win_len), 64'd0);

    // R6 R7: boundaries and field split in the 256 MiB window
    do_look(36'h0_B000_0000);
    do_look(36'h0_BFFF_FFFF);
    do_look(36'h0_C000_0000);
    do_look(36'h0_AFFF_FFFF);
    do_look(36'h0_B000_0000 + (36'd3 << 20) + (36'd5 << 15) + (36'd2 << 12) + 36'h44);
    // R6: lk_valid low gives no hit
    idle(); lk_addr = 36'h0_B000_1000; tick();

    // R3: 128 MiB with bit 27 of the base significant
    do_write(8'h0F, 64'h0000_0000_E800_0003);
    do_look(36'h0_E800_0000);
    do_look(36'h0_EFFF_FFFF);
    do_look(36'h0_E7FF_FFFF);
    // R3: 64 MiB with bit 26 significant
    do_write(8'h0F, 64'h0000_0000_E400_0005);
    do_look(36'h0_E7FF_FFFF);
    do_look(36'h0_E800_0000);

    // R4: reserved code keeps the old window, R9 shows the written value
    do_write(8'h0F, 64'h0000_0000_1234_5007);
    do_look(36'h0_E400_0010);
    tick();
    // R5: byte 0 only; R2: enable clear blocks hits
    do_write(8'h01, 64'hFFFF_FFFF_FFFF_FF00);
    do_look(36'h0_1000_0000);
    // R5: no byte enabled changes nothing, even with a reserved code
    do_write(8'h00, 64'hFFFF_FFFF_FFFF_FFFF);
    // R5: upper bytes then enable
    do_write(8'hF0, 64'hA5A5_A50A_0000_0000);
    do_write(8'h01, 64'h0000_0000_0000_0001);
    do_look(36'hA_1000_0000 + 36'h0FF_F123);

    // R8: restore wins over a simultaneous write
    idle(); rs_en = 1; rs_data = 64'h0000_0000_C000_0003;
    wr_en = 1; wr_be = 8'hFF; wr_data = 64'h0; tick(); idle();
    do_look(36'h0_C7FF_FFFF);
    // lookup in the same cycle as a write still sees the old window (R6)
    idle(); lk_valid = 1; lk_addr = 36'h0_C000_0000;
    wr_en = 1; wr_be = 8'h01; wr_data = 64'h0; tick(); idle();
    tick();

    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      idle();
      lk_valid = $urandom_range(0, 3) != 0;
      lk_addr  = ($urandom_range(0, 1) != 0) ?
                 (m_base + 36'($urandom_range(0, 32'h0FFF_FFFF))) :
                 {4'($urandom), 32'($urandom)};
      if ($urandom_range(0, 5) == 0) begin
        wr_en   = 1;
        wr_be   = 8'($urandom);
        wr_data = {32'($urandom), 32'($urandom)};
      end
      if ($urandom_range(0, 20) == 0) begin
        rs_en   = 1;
        rs_data = {32'($urandom), 32'($urandom)};
      end
      tick();
    end
    idle(); tick();
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    #2;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule